// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block is a small set-associative cache that holds recent address translations. It is keyed by a virtual page number (VPN) and returns the full page table entry (PTE) stored for that page. A lookup that hits hands the entry back directly, so the whole multi-level table walk is skipped. A lookup that misses reports the miss. The external walker then resolves the entry and writes it in through the fill port.

Every block holds exactly one PTE, so the VPN has no offset bits. Its low bits select a set, and the remaining upper bits form the tag. The tag is compared against both ways of the selected set. Stored entries never change by themselves. When page tables are edited, software issues an invalidate command, either for one VPN or for the whole buffer. Within a set, replacement uses one least-recently-used bit.

Top module: `tlb_cache`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` and `rsp_hit` are 0, and any lookup misses.
- R2: A lookup request produces exactly one response with `rsp_valid` high in the following cycle. Without a request in the previous cycle, `rsp_valid` is low.
- R3: A lookup of a filled VPN returns `rsp_hit` = 1 and the exact PTE that was filled.
- R4: A lookup that misses returns `rsp_hit` = 0 and `rsp_pte` = 0.
- R5: The set index is the low 4 bits of the VPN and the tag is the VPN bits above them. Two VPNs with the same index and different tags are held at once, one in each of the 2 ways.
- R6: A fill writes into an invalid way of the set when one exists. Otherwise it evicts the way that was least recently used by a hit or a fill.
- R7: A fill of a VPN that is already present overwrites that entry in place, and the other way of the set is kept.
- R8: A single-page invalidate clears only the entry whose VPN matches. The other entries of the same set stay valid.
- R9: A global invalidate clears every entry in one cycle. A lookup issued in the following cycle misses.
- R10: When a fill and an invalidate that covers its VPN (single-page with the same VPN, or global) arrive in the same cycle, the invalidate wins and the VPN is absent afterwards.
- R11: A lookup sees the contents present before its cycle's updates. A lookup issued together with a fill of the same VPN misses, and the next lookup of that VPN hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | VPN to look up |
| fill_en | input | 1 | Write a walked entry |
| fill_vpn | input | VPN_W | VPN of the fill |
| fill_pte | input | PTE_W | Entry written by the fill |
| inv_one | input | 1 | Invalidate the entry for `inv_vpn` |
| inv_vpn | input | VPN_W | VPN for a single-page invalidate |
| inv_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_pte | output | PTE_W | Entry returned on a hit, zero on a miss |

## Verification
Two operations can target the same translation in one cycle: a fill and an invalidate of the same VPN. The bench provokes this with both a single-page and a global invalidate. In each case it judges the outcome by a later lookup, which must miss even when the VPN was already cached before that cycle. A second collision is a lookup issued alongside a fill of the same VPN. That lookup must report the earlier state, a miss, and the next lookup must hit. The scoreboard expects exactly these outcomes.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Two ways per set; replacement state is a single bit naming the victim way.
  localparam int unsigned TLB_WAYS = 2;
  localparam int unsigned WAY_W    = 1;
  typedef logic [WAY_W-1:0] way_t;
endpackage

// File: rtl/tlb_way_store.sv
module tlb_way_store #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned TAG_W = 16,
  parameter int unsigned PTE_W = 32,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid,
  output logic [TAG_W-1:0] lk_tag,
  output logic [PTE_W-1:0] lk_pte,
  input  logic [IDX_W-1:0] fl_idx,
  output logic             fl_valid,
  output logic [TAG_W-1:0] fl_tag,
  input  logic [IDX_W-1:0] iv_idx,
  output logic             iv_valid,
  output logic [TAG_W-1:0] iv_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PTE_W-1:0] wr_pte,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             clr_all
);
  logic [SETS-1:0] valid_q, valid_d;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [PTE_W-1:0] pte_q [SETS];

  // A write to a set outranks a clear of the same set: the top only lets both
  // happen when the clear targets a different VPN than the one being written.
  always_comb begin
    valid_d = valid_q;
    for (int s = 0; s < SETS; s++) begin
      if (wr_en && (wr_idx == IDX_W'(s))) begin
        valid_d[s] = 1'b1;
      end else if (clr_all || (clr_en && (clr_idx == IDX_W'(s)))) begin
        valid_d[s] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      pte_q[wr_idx] <= wr_pte;
    end
  end

  assign lk_valid = valid_q[lk_idx];
  assign lk_tag   = tag_q[lk_idx];
  assign lk_pte   = pte_q[lk_idx];
  assign fl_valid = valid_q[fl_idx];
  assign fl_tag   = tag_q[fl_idx];
  assign iv_valid = valid_q[iv_idx];
  assign iv_tag   = tag_q[iv_idx];
endmodule

// File: rtl/tlb_tag_match.sv
module tlb_tag_match
  import tlb_pkg::*;
#(
  parameter int unsigned WAYS  = TLB_WAYS,
  parameter int unsigned TAG_W = 16
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           key,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output way_t                       hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid[w] && (tags[w] == key);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = way_t'(w);
    end
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru
  import tlb_pkg::*;
#(
  parameter int unsigned SETS = 16,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  way_t             touch_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  way_t             fill_way,
  input  logic [IDX_W-1:0] query_idx,
  output way_t             victim
);
  // Each bit names the way to evict next in its set.
  logic [SETS-1:0] vict_q, vict_d;

  always_comb begin
    vict_d = vict_q;
    if (touch_en) vict_d[touch_idx] = ~touch_way;
    if (fill_en)  vict_d[fill_idx]  = ~fill_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vict_q <= '0;
    end else begin
      vict_q <= vict_d;
    end
  end

  assign victim = vict_q[query_idx];
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
  import tlb_pkg::*;
#(
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PTE_W = 32,
  parameter int unsigned SETS  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PTE_W-1:0] fill_pte,
  input  logic             inv_one,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             inv_all,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PTE_W-1:0] rsp_pte
);
  localparam int unsigned WAYS  = TLB_WAYS;
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = VPN_W - IDX_W;

  // Key split: no offset field, index below tag.
  logic [IDX_W-1:0] lk_idx, fl_idx, iv_idx;
  logic [TAG_W-1:0] lk_tag, fl_tag, iv_tag;
  assign lk_idx = lk_vpn[IDX_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
  assign fl_idx = fill_vpn[IDX_W-1:0];
  assign fl_tag = fill_vpn[VPN_W-1:IDX_W];
  assign iv_idx = inv_vpn[IDX_W-1:0];
  assign iv_tag = inv_vpn[VPN_W-1:IDX_W];

  logic [WAYS-1:0]            lk_valid_w, fl_valid_w, iv_valid_w;
  logic [WAYS-1:0][TAG_W-1:0] lk_tag_w, fl_tag_w, iv_tag_w;
  logic [WAYS-1:0][PTE_W-1:0] lk_pte_w;
  logic [WAYS-1:0]            wr_en_w, clr_en_w;

  logic [WAYS-1:0] lk_hit_vec, fl_hit_vec, iv_hit_vec;
  logic            lk_hit, fl_hit, iv_hit;
  way_t            lk_way, fl_way, iv_way;

  // An invalidate covering the fill's VPN suppresses the fill.
  logic fill_ok;
  assign fill_ok = fill_en && !inv_all && !(inv_one && (inv_vpn == fill_vpn));

  way_t lru_victim, fill_way;
  logic any_free;
  way_t free_way;

  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!fl_valid_w[w]) begin
        any_free = 1'b1;
        free_way = way_t'(w);
      end
    end
  end

  // Priority: same VPN in place, then a free way, then the LRU victim.
  always_comb begin
    if (fl_hit)        fill_way = fl_way;
    else if (any_free) fill_way = free_way;
    else               fill_way = lru_victim;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign wr_en_w[w]  = fill_ok && (fill_way == way_t'(w));
    assign clr_en_w[w] = inv_one && iv_hit_vec[w];

    tlb_way_store #(
      .SETS  (SETS),
      .TAG_W (TAG_W),
      .PTE_W (PTE_W)
    ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_idx   (lk_idx),
      .lk_valid (lk_valid_w[w]),
      .lk_tag   (lk_tag_w[w]),
      .lk_pte   (lk_pte_w[w]),
      .fl_idx   (fl_idx),
      .fl_valid (fl_valid_w[w]),
      .fl_tag   (fl_tag_w[w]),
      .iv_idx   (iv_idx),
      .iv_valid (iv_valid_w[w]),
      .iv_tag   (iv_tag_w[w]),
      .wr_en    (wr_en_w[w]),
      .wr_idx   (fl_idx),
      .wr_tag   (fl_tag),
      .wr_pte   (fill_pte),
      .clr_en   (clr_en_w[w]),
      .clr_idx  (iv_idx),
      .clr_all  (inv_all)
    );
  end

  tlb_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .valid   (lk_valid_w),
    .tags    (lk_tag_w),
    .key     (lk_tag),
    .hit_vec (lk_hit_vec),
    .hit     (lk_hit),
    .hit_way (lk_way)
  );

  tlb_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_match (
    .valid   (fl_valid_w),
    .tags    (fl_tag_w),
    .key     (fl_tag),
    .hit_vec (fl_hit_vec),
    .hit     (fl_hit),
    .hit_way (fl_way)
  );

  tlb_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_iv_match (
    .valid   (iv_valid_w),
    .tags    (iv_tag_w),
    .key     (iv_tag),
    .hit_vec (iv_hit_vec),
    .hit     (iv_hit),
    .hit_way (iv_way)
  );

  tlb_lru #(.SETS(SETS)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (lk_req && lk_hit),
    .touch_idx (lk_idx),
    .touch_way (lk_way),
    .fill_en   (fill_ok),
    .fill_idx  (fl_idx),
    .fill_way  (fill_way),
    .query_idx (fl_idx),
    .victim    (lru_victim)
  );

  // Response stage.
  logic [PTE_W-1:0] pte_sel;
  logic             rsp_valid_d, rsp_hit_d;
  logic [PTE_W-1:0] rsp_pte_d;

  always_comb begin
    pte_sel = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_hit_vec[w]) pte_sel = pte_sel | lk_pte_w[w];
    end
  end

  always_comb begin
    rsp_valid_d = lk_req;
    rsp_hit_d   = lk_req && lk_hit;
    rsp_pte_d   = (lk_req && lk_hit) ? pte_sel : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pte   <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_hit   <= rsp_hit_d;
      rsp_pte   <= rsp_pte_d;
    end
  end
endmodule

// File: rtl/tlb_cache_chk.sv
module tlb_cache_chk #(
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PTE_W = 32,
  parameter int unsigned WAYS  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_req,
  input logic [VPN_W-1:0] lk_vpn,
  input logic             fill_en,
  input logic [VPN_W-1:0] fill_vpn,
  input logic             inv_one,
  input logic [VPN_W-1:0] inv_vpn,
  input logic             inv_all,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [PTE_W-1:0] rsp_pte,
  input logic [WAYS-1:0]  lk_hit_vec
);
  logic             kill_q;
  logic [VPN_W-1:0] kill_vpn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kill_q     <= 1'b0;
      kill_vpn_q <= '0;
    end else begin
      kill_q     <= fill_en && inv_one && (inv_vpn == fill_vpn);
      kill_vpn_q <= fill_vpn;
    end
  end

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);

  p_no_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid);

  p_hit_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  p_miss_pte_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_pte == '0));

  p_single_way_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec));

  p_flush_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all ##1 lk_req) |=> !rsp_hit);

  p_inv_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_q && lk_req && (lk_vpn == kill_vpn_q)) |=> !rsp_hit);
endmodule

bind tlb_cache tlb_cache_chk #(
  .VPN_W (VPN_W),
  .PTE_W (PTE_W),
  .WAYS  (WAYS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_req     (lk_req),
  .lk_vpn     (lk_vpn),
  .fill_en    (fill_en),
  .fill_vpn   (fill_vpn),
  .inv_one    (inv_one),
  .inv_vpn    (inv_vpn),
  .inv_all    (inv_all),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_pte    (rsp_pte),
  .lk_hit_vec (lk_hit_vec)
);

// File: tb/tb_tlb_cache.sv
module tb_tlb_cache;
  localparam int CLK_PERIOD = 10;
  localparam int VPN_W = 20;
  localparam int PTE_W = 32;
  localparam int WATCHDOG = 20000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             lk_req, fill_en, inv_one, inv_all;
  logic [VPN_W-1:0] lk_vpn, fill_vpn, inv_vpn;
  logic [PTE_W-1:0] fill_pte;
  logic             rsp_valid, rsp_hit;
  logic [PTE_W-1:0] rsp_pte;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  bit               exp_hit_q [$];
  logic [PTE_W-1:0] exp_pte_q [$];
  string            exp_tag_q [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  tlb_cache #(.VPN_W(VPN_W), .PTE_W(PTE_W), .SETS(16)) dut (
    .clk (clk), .rst_n (rst_n),
    .lk_req (lk_req), .lk_vpn (lk_vpn),
    .fill_en (fill_en), .fill_vpn (fill_vpn), .fill_pte (fill_pte),
    .inv_one (inv_one), .inv_vpn (inv_vpn), .inv_all (inv_all),
    .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_pte (rsp_pte)
  );

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    lk_req = 1'b0; fill_en = 1'b0; inv_one = 1'b0; inv_all = 1'b0;
  endtask

  // Driver pieces: set up an operation for the coming edge; step() commits.
  task automatic put_lookup(logic [VPN_W-1:0] v, bit hit, logic [PTE_W-1:0] pte, string tag);
    lk_req = 1'b1; lk_vpn = v;
    exp_hit_q.push_back(hit);
    exp_pte_q.push_back(hit ? pte : '0);
    exp_tag_q.push_back(tag);
  endtask

  task automatic put_fill(logic [VPN_W-1:0] v, logic [PTE_W-1:0] pte);
    fill_en = 1'b1; fill_vpn = v; fill_pte = pte;
  endtask

  task automatic lookup(logic [VPN_W-1:0] v, bit hit, logic [PTE_W-1:0] pte, string tag);
    put_lookup(v, hit, pte, tag);
    step();
  endtask

  task automatic fill(logic [VPN_W-1:0] v, logic [PTE_W-1:0] pte);
    put_fill(v, pte);
    step();
  endtask

  // Monitor: pops one expected item for each response.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_hit_q.size() == 0) begin
        check(1'b0, "R2", "unexpected response", 64'(rsp_valid), 64'd0);
      end else begin
        bit               eh;
        logic [PTE_W-1:0] ep;
        string            et;
        eh = exp_hit_q.pop_front();
        ep = exp_pte_q.pop_front();
        et = exp_tag_q.pop_front();
        check(rsp_hit == eh, et, "hit flag", 64'(rsp_hit), 64'(eh));
        check(rsp_pte == ep, et, "entry", 64'(rsp_pte), 64'(ep));
      end
    end
  end

  localparam logic [VPN_W-1:0] VA = 20'h12345;
  localparam logic [VPN_W-1:0] VB = 20'h22345;
  localparam logic [VPN_W-1:0] VC = 20'h32345;
  localparam logic [VPN_W-1:0] VD = 20'h42345;
  localparam logic [VPN_W-1:0] VE = 20'h0000A;
  localparam logic [VPN_W-1:0] VF = 20'h1000B;

  initial begin
    rst_n = 1'b0;
    lk_req = 1'b0; fill_en = 1'b0; inv_one = 1'b0; inv_all = 1'b0;
    lk_vpn = '0; fill_vpn = '0; inv_vpn = '0; fill_pte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check(rsp_hit == 1'b0, "R1", "rsp_hit after reset", 64'(rsp_hit), 64'd0);

    lookup(20'h00005, 1'b0, '0, "R1");
    lookup(VA, 1'b0, '0, "R4");
    step();
    check(rsp_valid == 1'b0, "R2", "idle cycle", 64'(rsp_valid), 64'd0);

    fill(VA, 32'hA000_0001);
    lookup(VA, 1'b1, 32'hA000_0001, "R3");

    // Lookup alongside a fill of the same VPN sees the old state.
    put_fill(VB, 32'hB000_0002);
    put_lookup(VB, 1'b0, '0, "R11");
    step();
    lookup(VB, 1'b1, 32'hB000_0002, "R11");
    lookup(VA, 1'b1, 32'hA000_0001, "R5");

    // A used last, so B is the victim for C.
    fill(VC, 32'hC000_0003);
    lookup(VB, 1'b0, '0, "R6");
    lookup(VA, 1'b1, 32'hA000_0001, "R6");
    lookup(VC, 1'b1, 32'hC000_0003, "R6");

    fill(VA, 32'hA000_00F2);
    lookup(VA, 1'b1, 32'hA000_00F2, "R7");
    lookup(VC, 1'b1, 32'hC000_0003, "R7");

    // C was used last, so the LRU bit names A; the freed way must win.
    inv_one = 1'b1; inv_vpn = VC;
    step();
    fill(VD, 32'hD000_0004);
    lookup(VA, 1'b1, 32'hA000_00F2, "R8");
    lookup(VC, 1'b0, '0, "R8");
    lookup(VD, 1'b1, 32'hD000_0004, "R6");

    // Fill and invalidate of the same VPN in one cycle.
    fill(VE, 32'hE000_0005);
    lookup(VE, 1'b1, 32'hE000_0005, "R3");
    put_fill(VE, 32'hE000_0055);
    inv_one = 1'b1; inv_vpn = VE;
    step();
    lookup(VE, 1'b0, '0, "R10");

    put_fill(VF, 32'hF000_0006);
    inv_all = 1'b1;
    step();
    lookup(VF, 1'b0, '0, "R10");
    lookup(VA, 1'b0, '0, "R9");

    for (int i = 0; i < 4; i++) begin
      fill((VPN_W'(i + 1) << 4) | VPN_W'(i), 32'h5000_0000 + 32'(i));
    end
    for (int i = 0; i < 4; i++) begin
      lookup((VPN_W'(i + 1) << 4) | VPN_W'(i), 1'b1, 32'h5000_0000 + 32'(i), "R9");
    end
    inv_all = 1'b1;
    step();
    for (int i = 0; i < 4; i++) begin
      lookup((VPN_W'(i + 1) << 4) | VPN_W'(i), 1'b0, '0, "R9");
    end

    repeat (3) step();
    check(exp_hit_q.size() == 0, "R2", "responses outstanding", 64'(exp_hit_q.size()), 64'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule